// File: doc/BRIEF.md
# GPIO Bank Interrupt Sense Controller

This block turns a bank of already synchronized general-purpose input pins into one interrupt request. Every pin has its own sense mode, built from one bit in each of three parallel type registers. The modes are rising edge, falling edge, either edge, high level and low level. When a pin's condition is met, the block records it in a sticky status bit. Software clears a status bit by writing a 1 to it. The interrupt output is asserted while any status bit is set and its pin is enabled.

Software reaches the bank through a plain word-wide register port with an address, a write strobe, write data and registered read data. An elaboration-time mask marks which pins can act as inputs. Pins outside the mask never record an event. Several such banks are normally combined by a higher-level interrupt tree.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset the enable, type and status registers, the read data and `irq_o` are all 0. The stored previous pin sample is also 0.
- R2: The byte offsets are 0x00 for enable, 0x04 for type0 (polarity), 0x08 for type1 (level select), 0x0C for type2 (either-edge) and 0x10 for status. `rd_data_o` shows the register addressed in the previous cycle, with the value it held before that clock edge. Reads of any other offset return 0, and writes to any other offset change nothing.
- R3: With type1=0 and type2=0, a pin detects edges. A type0 bit of 1 selects rising edges and a type0 bit of 0 selects falling edges. The edge is found by comparing the current sample with the sample from the previous clock, and the status bit is set at the clock edge that first samples the new pin value.
- R4: With type1=0 and type2=1, both rising and falling edges set the status bit, whatever the type0 bit holds.
- R5: With type1=1, a pin senses a level, and type2 has no effect. A type0 bit of 1 means active high and 0 means active low. The status bit is set at every clock edge while the active level is present.
- R6: A status bit stays set until a write to offset 0x10 carries a 1 in that bit position. A 0 in the written data leaves the bit unchanged, and a write to status never sets a bit.
- R7: If a clear write and a new event for the same pin fall on the same clock edge, the status bit stays set. As a result, a level-sensitive pin cannot be cleared while its active level persists.
- R8: Pins whose bit is 0 in the `CAP_MASK` parameter never set a status bit, in any mode. The default mask leaves pins 24 to 27 without input capability.
- R9: At each clock edge, `irq_o` is registered from the OR of (status AND enable) over all pins, so it follows the status by one cycle. A pin with enable=0 can still set its status bit, but it does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Synchronized pin samples |
| addr_i | input | 5 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | NPINS | Write data |
| rd_data_o | output | NPINS | Registered read data |
| irq_o | output | 1 | Registered bank interrupt request |

## Verification
The assertions take `pin_i` to be already synchronized, so a new value is sampled once at one clock edge. They also take the address, write strobe and data to be stable across that edge. The stimulus changes every input only at the falling clock edge, and it changes pins freely, including several pins in one cycle. Random writes fall on all five registers and on one unmapped offset. Random clear writes may land on the same edge as new edge or level events, and the model has to resolve those collisions.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_ENABLE = 5'h00;
  localparam logic [REG_AW-1:0] OFS_POL    = 5'h04;
  localparam logic [REG_AW-1:0] OFS_LEVEL  = 5'h08;
  localparam logic [REG_AW-1:0] OFS_ANY    = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_STATUS = 5'h10;

  // Per-pin sense configuration gathered from the three type registers
  typedef struct packed {
    logic pol;   // 1: rising / active high, 0: falling / active low
    logic lvl;   // 1: level sensing, 0: edge sensing
    logic any;   // edge sensing only: either edge
  } sense_cfg_t;

  function automatic logic pin_event(input logic cur, input logic prev,
                                     input sense_cfg_t cfg);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (cfg.lvl) return cfg.pol ? cur : ~cur;
    if (cfg.any) return rise | fall;
    return cfg.pol ? rise : fall;
  endfunction

endpackage

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter logic [NPINS-1:0] CAP_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] any_i,
  output logic [NPINS-1:0] evt_o
);

  logic [NPINS-1:0] pin_q;
  logic [NPINS-1:0] raw_evt;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    sense_cfg_t cfg;
    assign cfg        = '{pol: pol_i[i], lvl: lvl_i[i], any: any_i[i]};
    assign raw_evt[i] = pin_event(pin_i[i], pin_q[i], cfg);
  end

  // Pins without input capability never report an event
  assign evt_o = raw_evt & CAP_MASK;

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter logic [NPINS-1:0] CAP_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [NPINS-1:0]  wr_data_i,
  input  logic [NPINS-1:0]  evt_i,
  output logic [NPINS-1:0]  en_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  lvl_o,
  output logic [NPINS-1:0]  any_o,
  output logic [NPINS-1:0]  status_o,
  output logic [NPINS-1:0]  rd_data_o
);

  logic [NPINS-1:0] en_q, pol_q, lvl_q, any_q, status_q, rd_q;
  logic [NPINS-1:0] clr_mask;
  logic [NPINS-1:0] rd_mux;
  logic             status_wr;

  assign status_wr = wr_en_i && (addr_i == OFS_STATUS);
  assign clr_mask  = status_wr ? wr_data_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pol_q <= '0;
      lvl_q <= '0;
      any_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFS_ENABLE: en_q  <= wr_data_i;
        OFS_POL:    pol_q <= wr_data_i;
        OFS_LEVEL:  lvl_q <= wr_data_i;
        OFS_ANY:    any_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  // New events take priority over a write-one-to-clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= evt_i | (status_q & ~clr_mask);
  end

  always_comb begin
    case (addr_i)
      OFS_ENABLE: rd_mux = en_q;
      OFS_POL:    rd_mux = pol_q;
      OFS_LEVEL:  rd_mux = lvl_q;
      OFS_ANY:    rd_mux = any_q;
      OFS_STATUS: rd_mux = status_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign en_o      = en_q;
  assign pol_o     = pol_q;
  assign lvl_o     = lvl_q;
  assign any_o     = any_q;
  assign status_o  = status_q;
  assign rd_data_o = rd_q;

  // R6: a set bit with no clear request stays set
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !status_wr |=> ((~status_q & $past(status_q)) == '0));

  // R6: a cleared bit with no coincident event is 0 afterwards
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    status_wr |=> ((status_q & $past(wr_data_i & ~evt_i)) == '0));

  // R3: every reported event is recorded at the next edge
  p_event_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R8: pins without input capability never hold status
  p_noncap_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~CAP_MASK) == '0);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter logic [NPINS-1:0] CAP_MASK = NPINS'(32'hF0FF_FFFF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [NPINS-1:0]  wr_data_i,
  output logic [NPINS-1:0]  rd_data_o,
  output logic              irq_o
);

  logic [NPINS-1:0] evt, en, pol, lvl, any, status;
  logic             irq_q;

  gpio_irq_sense #(.NPINS(NPINS), .CAP_MASK(CAP_MASK)) u_sense (
    .clk   (clk),
    .rst   (rst),
    .pin_i (pin_i),
    .pol_i (pol),
    .lvl_i (lvl),
    .any_i (any),
    .evt_o (evt)
  );

  gpio_irq_regs #(.NPINS(NPINS), .CAP_MASK(CAP_MASK)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .evt_i     (evt),
    .en_o      (en),
    .pol_o     (pol),
    .lvl_o     (lvl),
    .any_o     (any),
    .status_o  (status),
    .rd_data_o (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status & en);
  end

  assign irq_o = irq_q;

  // R9: the request only rises when an enabled status bit was pending
  p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(|(status & en)));

  // R9: with nothing enabled the request is low one cycle later
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq_o);

endmodule

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;
  import gpio_irq_pkg::*;

  localparam int N = 32;
  localparam logic [N-1:0] CAP = 32'hF0FF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pins = '0;
  logic [N-1:0] wd = '0;
  logic [4:0]   addr = '0;
  logic         we = 1'b0;
  logic [N-1:0] rd;
  logic         irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [N-1:0] m_en = '0, m_pol = '0, m_lvl = '0, m_any = '0, m_st = '0, m_prev = '0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.NPINS(N), .CAP_MASK(CAP)) dut_i (
    .clk(clk), .rst(rst), .pin_i(pins), .addr_i(addr), .wr_en_i(we),
    .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_en;
      5'h04: return m_pol;
      5'h08: return m_lvl;
      5'h0C: return m_any;
      5'h10: return m_st;
      default: return '0;
    endcase
  endfunction

  function automatic logic [N-1:0] m_evt(input logic [N-1:0] p);
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) begin
      if (m_lvl[i])      e[i] = m_pol[i] ? p[i] : !p[i];
      else if (m_any[i]) e[i] = p[i] != m_prev[i];
      else if (m_pol[i]) e[i] = p[i] && !m_prev[i];
      else               e[i] = !p[i] && m_prev[i];
    end
    return e & CAP;
  endfunction

  // One clock: drive at falling edge, update model, compare after rising edge
  task automatic step(input logic [N-1:0] p, input logic [4:0] a, input logic w,
                      input logic [N-1:0] d);
    logic [N-1:0] exp_rd, ev, clr;
    logic exp_irq;
    @(negedge clk);
    pins = p; addr = a; we = w; wd = d;
    exp_rd  = m_read(a);
    exp_irq = |(m_st & m_en);
    ev  = m_evt(p);
    clr = (w && a == 5'h10) ? d : '0;
    m_st = ev | (m_st & ~clr);
    if (w) begin
      case (a)
        5'h00: m_en  = d;
        5'h04: m_pol = d;
        5'h08: m_lvl = d;
        5'h0C: m_any = d;
        default: ;
      endcase
    end
    m_prev = p;
    @(posedge clk); #1;
    chk((a == 5'h10) ? "R6 status readback" : "R2 register readback", rd, exp_rd);
    chk("R9 irq follows model", {31'b0, irq}, {31'b0, exp_irq});
  endtask

  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    step(pins, a, 1'b1, d);
  endtask

  task automatic see_status(input logic [N-1:0] exp, input string tag);
    step(pins, 5'h10, 1'b0, '0);
    chk(tag, rd, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 irq after reset", {31'b0, irq}, '0);
    chk("R1 rd after reset", rd, '0);
    for (int k = 0; k < 5; k++) begin
      step(pins, 5'(k * 4), 1'b0, '0);
      chk("R1 register zero after reset", rd, '0);
    end

    // R2 readback and unmapped offset
    wr(5'h00, 32'hA5A5_0F0F); step(pins, 5'h00, 0, '0); chk("R2 enable readback", rd, 32'hA5A5_0F0F);
    wr(5'h04, 32'h1234_5678); step(pins, 5'h04, 0, '0); chk("R2 type0 readback", rd, 32'h1234_5678);
    wr(5'h0C, 32'h0F0F_00FF); step(pins, 5'h0C, 0, '0); chk("R2 type2 readback", rd, 32'h0F0F_00FF);
    wr(5'h08, 32'h00C0_0300); step(pins, 5'h08, 0, '0); chk("R2 type1 readback", rd, 32'h00C0_0300);
    wr(5'h08, '0);
    wr(5'h14, '1); step(pins, 5'h14, 0, '0); chk("R2 unmapped reads zero", rd, '0);
    step(pins, 5'h00, 0, '0); chk("R2 unmapped write ignored", rd, 32'hA5A5_0F0F);

    wr(5'h00, '1); wr(5'h04, '0); wr(5'h0C, '0); wr(5'h10, '1);
    see_status('0, "R6 all cleared");

    // R3 rising edge on pin 0
    wr(5'h04, 32'h1);
    step(32'h1, 5'h00, 0, '0);
    chk("R9 irq lags status", {31'b0, irq}, '0);
    see_status(32'h1, "R3 rising edge");
    chk("R9 irq one cycle later", {31'b0, irq}, 32'h1);
    wr(5'h10, 32'h1);
    see_status('0, "R6 write one clears");

    // R3 falling edge on pin 1
    step(32'h3, 5'h00, 0, '0);
    see_status('0, "R3 rise ignored in falling mode");
    step(32'h1, 5'h00, 0, '0);
    see_status(32'h2, "R3 falling edge");
    wr(5'h10, '0);
    see_status(32'h2, "R6 zero write keeps bit");
    wr(5'h10, 32'h2);
    see_status('0, "R6 clear pin1");

    // R4 either edge on pin 2
    wr(5'h0C, 32'h4); wr(5'h04, 32'h5);
    step(32'h5, 5'h00, 0, '0);
    see_status(32'h4, "R4 rise in either-edge mode");
    wr(5'h10, 32'h4); wr(5'h04, 32'h1);
    step(32'h1, 5'h00, 0, '0);
    see_status(32'h4, "R4 fall with type0=0");
    wr(5'h10, 32'h4);
    see_status('0, "R4 cleared");

    // R5 / R7 level on pin 3
    wr(5'h08, 32'h8); wr(5'h04, 32'h9);
    step(32'h9, 5'h00, 0, '0);
    see_status(32'h8, "R5 active high level");
    wr(5'h10, 32'h8);
    see_status(32'h8, "R7 level holds against clear");
    step(32'h1, 5'h00, 0, '0);
    wr(5'h10, 32'h8);
    see_status('0, "R5 clears once level gone");
    wr(5'h04, 32'h1);
    step(pins, 5'h00, 0, '0);
    see_status(32'h8, "R5 active low level");
    wr(5'h08, '0);
    wr(5'h10, 32'h8);
    see_status('0, "R5 cleared after mode change");

    // R7 edge and clear in the same cycle
    step(32'h0, 5'h00, 0, '0);
    step(32'h1, 5'h00, 0, '0);
    step(32'h0, 5'h00, 0, '0);
    step(32'h1, 5'h10, 1, 32'h1);
    see_status(32'h1, "R7 event beats clear");
    wr(5'h10, 32'h1);
    see_status('0, "R7 cleared afterwards");

    // R8 pin 25 lacks input capability
    wr(5'h04, 32'h0200_0001);
    step(32'h0200_0001, 5'h00, 0, '0);
    step(32'h0000_0001, 5'h00, 0, '0);
    see_status('0, "R8 edge on non-capable pin");
    wr(5'h08, 32'h0200_0000);
    step(32'h0200_0001, 5'h00, 0, '0);
    step(32'h0200_0001, 5'h00, 0, '0);
    see_status('0, "R8 level on non-capable pin");
    chk("R8 no irq from non-capable pin", {31'b0, irq}, '0);
    wr(5'h08, '0);

    // R9 disabled pin
    wr(5'h00, ~32'h1);
    step(32'h0, 5'h00, 0, '0);
    step(32'h1, 5'h00, 0, '0);
    step(pins, 5'h00, 0, '0);
    step(pins, 5'h00, 0, '0);
    chk("R9 disabled pin gives no irq", {31'b0, irq}, '0);
    see_status(32'h1, "R9 disabled pin still records");
    wr(5'h00, '1);
    step(pins, 5'h00, 0, '0);
    chk("R9 enabling raises irq", {31'b0, irq}, 32'h1);
    wr(5'h10, 32'h1);
    step(pins, 5'h00, 0, '0);
    chk("R9 irq drops after clear", {31'b0, irq}, '0);

    // Random phase against the model
    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] p, d;
      logic [4:0] a;
      logic w;
      p = pins ^ ($urandom & $urandom & $urandom);
      a = 5'(($urandom % 6) * 4);
      w = ($urandom % 4) == 0;
      d = $urandom;
      step(p, a, w, d);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule